// File: doc/BRIEF.md
# Vectored Interrupt Controller (eight lines)

This block collects up to eight interrupt request lines and presents one interrupt output to a processor. When the processor acknowledges, the block returns an 8-bit vector for the line that won. Software reaches the block through two byte addresses. Address 0 is the command port and address 1 is the data port. Software first writes an initialisation sequence, which sets the vector base and the operating mode and may include a cascade word. After that it can mask lines, choose which internal register a command-port read returns, rotate the priority order, and end interrupt service.

A rising edge on an input latches that line's request. A priority resolver with a programmable lowest-priority line picks the most urgent unmasked request and compares it with the most urgent line in service. The interrupt output is raised only when the new request outranks every line in service. An acknowledge moves the winning request into service and loads the vector, which is the base plus the line index. Service ends either through an end-of-interrupt command or, in automatic mode, at the acknowledge itself.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `int_out` is low. A data-port read returns 0xFF, because all lines are masked. A command-port read returns the request register, which is 0x00. Reset also sets the vector base to 0x00.
- R2: A command write with bit 4 set starts initialisation, and the data writes that follow are taken in this order:
  - the vector base;
  - a cascade word, only when bit 1 of the command was 0;
  - a mode word, only when bit 0 of the command was 1.

  After the last expected word the block is ready, and the next data write loads the mask. With 0x13 the cascade word is skipped and `casc_word` keeps its old value.
- R3: Starting initialisation has these effects:
  - it clears the request, in-service and mask registers;
  - it makes line 0 the highest priority;
  - it selects the request register for command reads.

  `int_out` stays low until the sequence completes, even while a request is latched.
- R4: Bit 0 of the mode word drives `cpu_mode86`, and bit 1 enables automatic end-of-interrupt. Both are 0 when no mode word is requested. The cascade word appears on `casc_word`.
- R5: Once ready, a data write loads the mask (bit n masks line n), and a data read returns it. With mask 0xFF, `int_out` stays low although requests are still latched.
- R6: A rising edge on `irq_in[n]` sets request bit n. A level held high after the acknowledge does not set the bit again.
- R7: `int_out` is high exactly when an unmasked request has a higher priority than every in-service line, or when it is unmasked and no line is in service.
- R8: An acknowledge (`inta` high for one cycle) while `int_out` is high has three effects after that clock edge:
  - `vec_out` becomes the base plus the winning line index, modulo 256;
  - the line's request bit is cleared;
  - its in-service bit is set.
- R9: In automatic end-of-interrupt mode, an acknowledge leaves the in-service register unchanged.
- R10: Command 0x20 clears the highest-priority in-service bit.
- R11: Command 0x60|n clears in-service bit n.
- R12: Command 0xC0|n makes line n the lowest priority, so the order runs n+1, n+2 and so on, wrapping round (n=2 gives 3,4,5,6,7,0,1,2).
- R13: Command 0x0A selects the request register and 0x0B selects the in-service register as the value returned by command-port reads.
- R14: An acknowledge while `int_out` is low loads `vec_out` with the base plus 7 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_addr | input | 1 | 0 selects the command port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| inta | input | 1 | Acknowledge strobe from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector loaded by the last acknowledge |
| casc_word | output | 8 | Stored cascade word |
| cpu_mode86 | output | 1 | Mode-word processor-type bit |

## Verification
The assertions assume that an acknowledge and a command write never fall in the same cycle, because the in-service counts they check would otherwise be changed twice. They also assume that the request lines are synchronous to `clk`. The directed bench drives every bus write, acknowledge and request edge on its own falling clock edge, one action at a time. It never overlaps an acknowledge with a command, so the stimulus stays inside those assumptions.

// File: rtl/vic_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes byte-wide register access and eight request lines.
package vic_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } init_st_t;

    // Decoded strobes of one register-bus cycle
    typedef struct packed {
        logic init_start;   // command write with bit 4 set
        logic mask_wr;      // data write while ready
        logic eoi_any;      // 0x20 non-specific end of interrupt
        logic eoi_line;     // 0x60|n specific end of interrupt
        logic set_low;      // 0xC0|n lowest-priority select
        logic sel_valid;    // read-select command with bit 1 set
        logic sel_isr;      // read-select target: 1 = in-service
    } cmd_t;

endpackage

// File: rtl/vic_cmd_dec.sv
// Command decoder: turns one register-bus write into single-cycle strobes.
// Assumes bus_wr is a one-cycle pulse per byte; purely combinational.
module vic_cmd_dec
    import vic_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IDXW = 3
) (
    input  logic            bus_wr,
    input  logic            bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            ready,
    output cmd_t            cmd,
    output logic [IDXW-1:0] line_sel
);
    logic cmd_wr;
    logic dat_wr;
    logic op_cmd;

    // Decode the write into strobes by address and command class
    always_comb begin
        cmd_wr = bus_wr && !bus_addr;
        dat_wr = bus_wr &&  bus_addr;
        op_cmd = cmd_wr && !bus_wdata[4] && !bus_wdata[3];
        cmd.init_start = cmd_wr && bus_wdata[4];
        cmd.mask_wr    = dat_wr && ready;
        cmd.eoi_any    = op_cmd && (bus_wdata[7:5] == 3'b001);
        cmd.eoi_line   = op_cmd && (bus_wdata[7:5] == 3'b011);
        cmd.set_low    = op_cmd && (bus_wdata[7:5] == 3'b110);
        cmd.sel_valid  = cmd_wr && !bus_wdata[4] && bus_wdata[3] && bus_wdata[1];
        cmd.sel_isr    = bus_wdata[0];
        line_sel       = bus_wdata[IDXW-1:0];
    end
endmodule

// File: rtl/vic_init_seq.sv
// Initialisation sequencer: after a start command, accepts the base,
// the optional cascade word and the optional mode word, in that order.
// Assumes data writes arrive one per cycle.
module vic_init_seq
    import vic_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_start,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic [DW-1:0] base,
    output logic [DW-1:0] casc,
    output logic          mode86,
    output logic          aeoi
);
    init_st_t state;
    logic     single;
    logic     want_mode;

    // Walk the word sequence and capture each configuration field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READY;
            base      <= '0;
            casc      <= '0;
            mode86    <= 1'b0;
            aeoi      <= 1'b0;
            single    <= 1'b0;
            want_mode <= 1'b0;
        end else if (init_start) begin
            state     <= ST_BASE;
            single    <= wdata[1];
            want_mode <= wdata[0];
            mode86    <= 1'b0;
            aeoi      <= 1'b0;
        end else if (data_wr) begin
            case (state)
                ST_BASE: begin
                    base <= wdata;
                    if (!single)       state <= ST_CASC;
                    else if (want_mode) state <= ST_MODE;
                    else                state <= ST_READY;
                end
                ST_CASC: begin
                    casc  <= wdata;
                    state <= want_mode ? ST_MODE : ST_READY;
                end
                ST_MODE: begin
                    mode86 <= wdata[0];
                    aeoi   <= wdata[1];
                    state  <= ST_READY;
                end
                default: state <= ST_READY;
            endcase
        end
    end

    // Ready flag for the rest of the block
    always_comb ready = (state == ST_READY);
endmodule

// File: rtl/vic_prio_res.sv
// Rotating priority resolver: finds the most urgent line in the request
// and in-service sets, with priority starting just above 'lowest'.
// Assumes N lines indexed by IDXW bits; combinational only.
module vic_prio_res #(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [N-1:0]    isr,
    input  logic [IDXW-1:0] lowest,
    output logic [IDXW-1:0] req_idx,
    output logic            isr_hit,
    output logic [IDXW-1:0] isr_idx,
    output logic            int_req
);
    logic            req_hit;
    logic [IDXW:0]   req_rank;
    logic [IDXW:0]   isr_rank;

    // Scan ranks from lowest to highest priority so the best rank wins
    always_comb begin
        req_hit  = 1'b0;
        req_idx  = '0;
        req_rank = '1;
        isr_hit  = 1'b0;
        isr_idx  = '0;
        isr_rank = '1;
        for (int k = N - 1; k >= 0; k--) begin
            int line;
            line = (int'(lowest) + 1 + k) % N;
            if (req[line]) begin
                req_hit  = 1'b1;
                req_idx  = IDXW'(line);
                req_rank = (IDXW+1)'(k);
            end
            if (isr[line]) begin
                isr_hit  = 1'b1;
                isr_idx  = IDXW'(line);
                isr_rank = (IDXW+1)'(k);
            end
        end
        int_req = req_hit && (!isr_hit || (req_rank < isr_rank));
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Eight-line vectored interrupt controller top: request capture, mask,
// in-service tracking, end-of-interrupt handling and vector delivery.
// Assumes irq_in is synchronous to clk and inta is a one-cycle strobe.
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  irq_in,
    input  logic          inta,
    output logic          int_out,
    output logic [DW-1:0] vec_out,
    output logic [DW-1:0] casc_word,
    output logic          cpu_mode86
);
    localparam int IDXW = $clog2(N);

    cmd_t            cmd;
    logic [IDXW-1:0] line_sel;
    logic            ready;
    logic            init_busy;
    logic [DW-1:0]   base;
    logic            aeoi;
    logic [N-1:0]    irq_prev;
    logic [N-1:0]    irr;
    logic [N-1:0]    isr;
    logic [N-1:0]    isr_nxt;
    logic [N-1:0]    mask;
    logic [IDXW-1:0] lowest;
    logic            rd_isr;
    logic [IDXW-1:0] req_idx;
    logic            isr_hit;
    logic [IDXW-1:0] isr_idx;
    logic            int_req;
    logic            ack_take;

    vic_cmd_dec #(.DW(DW), .IDXW(IDXW)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ready     (ready),
        .cmd       (cmd),
        .line_sel  (line_sel)
    );

    vic_init_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_start (cmd.init_start),
        .data_wr    (bus_wr && bus_addr),
        .wdata      (bus_wdata),
        .ready      (ready),
        .base       (base),
        .casc       (casc_word),
        .mode86     (cpu_mode86),
        .aeoi       (aeoi)
    );

    vic_prio_res #(.N(N), .IDXW(IDXW)) u_res (
        .req     (irr & ~mask),
        .isr     (isr),
        .lowest  (lowest),
        .req_idx (req_idx),
        .isr_hit (isr_hit),
        .isr_idx (isr_idx),
        .int_req (int_req)
    );

    // Interrupt output and acknowledge acceptance
    always_comb begin
        init_busy = !ready;
        int_out   = ready && int_req;
        ack_take  = inta && int_out;
    end

    // Remember last input levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) irq_prev <= '0;
        else        irq_prev <= irq_in;
    end

    // One request latch per line: set on rising edge, cleared on acknowledge
    for (genvar i = 0; i < N; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (!rst_n || cmd.init_start)
                irr[i] <= 1'b0;
            else if (irq_in[i] && !irq_prev[i])
                irr[i] <= 1'b1;
            else if (ack_take && (req_idx == IDXW'(i)))
                irr[i] <= 1'b0;
        end
    end

    // Next in-service value from acknowledge and end-of-interrupt commands
    always_comb begin
        isr_nxt = isr;
        if (ack_take && !aeoi)       isr_nxt[req_idx]  = 1'b1;
        if (cmd.eoi_any && isr_hit)  isr_nxt[isr_idx]  = 1'b0;
        if (cmd.eoi_line)            isr_nxt[line_sel] = 1'b0;
    end

    // In-service register
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.init_start) isr <= '0;
        else                          isr <= isr_nxt;
    end

    // Mask register: all masked at reset, cleared by initialisation
    always_ff @(posedge clk) begin
        if (!rst_n)            mask <= '1;
        else if (cmd.init_start) mask <= '0;
        else if (cmd.mask_wr)  mask <= bus_wdata[N-1:0];
    end

    // Lowest-priority line and command-read select
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.init_start) begin
            lowest <= IDXW'(N - 1);
            rd_isr <= 1'b0;
        end else begin
            if (cmd.set_low)   lowest <= line_sel;
            if (cmd.sel_valid) rd_isr <= cmd.sel_isr;
        end
    end

    // Vector register, loaded on every acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_out <= '0;
        else if (inta)
            vec_out <= ack_take ? base + DW'(req_idx) : base + DW'(N - 1);
    end

    // Read mux: data port gives the mask, command port the selected register
    always_comb begin
        if (bus_addr) bus_rdata = DW'(mask);
        else          bus_rdata = rd_isr ? DW'(isr) : DW'(irr);
    end
endmodule

// File: rtl/vic_checker.sv
// Property checker for irq_vector_ctrl, attached by bind.
// Assumes acknowledge and command writes do not share a cycle.
module vic_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         bus_addr,
    input logic [7:0]   bus_wdata,
    input logic         inta,
    input logic         int_out,
    input logic         init_busy,
    input logic         aeoi,
    input logic [N-1:0] irr,
    input logic [N-1:0] isr,
    input logic [N-1:0] mask
);
    a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (isr == '0 && mask == '0 && irr == '0));

    a_r3_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> !int_out);

    a_r7_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0));

    a_r8_ack_adds_service: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !aeoi && !bus_wr) |=> ($countones(isr) == $past($countones(isr)) + 1));

    a_r9_auto_end_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && aeoi && !bus_wr) |=> (isr == $past(isr)));

    a_r10_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata == 8'h20 && isr != '0 && !inta)
        |=> ($countones(isr) == $past($countones(isr)) - 1));
endmodule

bind irq_vector_ctrl vic_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .inta      (inta),
    .int_out   (int_out),
    .init_busy (init_busy),
    .aeoi      (aeoi),
    .irr       (irr),
    .isr       (isr),
    .mask      (mask)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       inta = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic [7:0] casc_word;
    logic       cpu_mode86;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .inta(inta), .int_out(int_out), .vec_out(vec_out),
        .casc_word(casc_word), .cpu_mode86(cpu_mode86)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] lines);
        @(negedge clk);
        irq_in = irq_in | lines;
        @(negedge clk);
        irq_in = irq_in & ~lines;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v = vec_out;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 int_out", int_out, 0);
        rd(1'b1, v); check("R1 mask", v, 8'hFF);
        rd(1'b0, v); check("R1 request reg", v, 8'h00);
    endtask

    task automatic t_cascaded_nesting;
        logic [7:0] v;
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        check("R4 cascade word", casc_word, 8'h04);
        check("R4 mode86 bit", cpu_mode86, 1);
        rd(1'b1, v); check("R3 mask cleared", v, 8'h00);
        wr(1, 8'hFF); rd(1'b1, v); check("R5 mask readback", v, 8'hFF);
        pulse(8'h08);
        check("R5 masked line quiet", int_out, 0);
        rd(1'b0, v); check("R6 request latched", v, 8'h08);
        wr(1, 8'h00);
        check("R7 unmasked raises", int_out, 1);
        ack(v); check("R8 vector line3", v, 8'h23);
        rd(1'b0, v); check("R8 request cleared", v, 8'h00);
        wr(0, 8'h0B); rd(1'b0, v); check("R13 in-service read", v, 8'h08);
        pulse(8'h20);
        check("R7 lower line blocked", int_out, 0);
        pulse(8'h02);
        check("R7 higher line nests", int_out, 1);
        ack(v); check("R8 vector line1", v, 8'h21);
        rd(1'b0, v); check("R8 two in service", v, 8'h0A);
        wr(0, 8'h20); rd(1'b0, v); check("R10 clears line1", v, 8'h08);
        check("R7 still blocked", int_out, 0);
        wr(0, 8'h20); rd(1'b0, v); check("R10 clears line3", v, 8'h00);
        check("R7 pending line5", int_out, 1);
        ack(v); check("R8 vector line5", v, 8'h25);
        wr(0, 8'h65); rd(1'b0, v); check("R11 specific clear", v, 8'h00);
        wr(0, 8'h0A); rd(1'b0, v); check("R13 request read", v, 8'h00);
    endtask

    task automatic t_level_hold;
        logic [7:0] v;
        @(negedge clk); irq_in[2] = 1'b1;
        @(negedge clk);
        ack(v); check("R8 vector line2", v, 8'h22);
        repeat (3) @(negedge clk);
        rd(1'b0, v); check("R6 held level no retrigger", v, 8'h00);
        wr(0, 8'h20);
        check("R6 quiet after eoi", int_out, 0);
        @(negedge clk); irq_in[2] = 1'b0;
    endtask

    task automatic t_rotation;
        logic [7:0] v;
        wr(0, 8'hC2);
        pulse(8'h12);
        ack(v); check("R12 line4 before line1", v, 8'h24);
        wr(0, 8'h20);
        ack(v); check("R12 line1 next", v, 8'h21);
        wr(0, 8'h20);
        check("R14 nothing pending", int_out, 0);
        ack(v); check("R14 spurious vector", v, 8'h27);
        wr(0, 8'h0B); rd(1'b0, v); check("R14 no service change", v, 8'h00);
        wr(0, 8'h0A);
    endtask

    task automatic t_single_auto;
        logic [7:0] v;
        wr(0, 8'h13); wr(1, 8'h40);
        pulse(8'h40);
        check("R3 quiet during init", int_out, 0);
        wr(1, 8'h03);
        check("R2 cascade skipped", casc_word, 8'h04);
        check("R4 mode86 set", cpu_mode86, 1);
        rd(1'b1, v); check("R2 mode word not mask", v, 8'h00);
        check("R3 raises once ready", int_out, 1);
        ack(v); check("R8 vector base40", v, 8'h46);
        wr(0, 8'h0B); rd(1'b0, v); check("R9 auto end no service", v, 8'h00);
        wr(1, 8'h5A); rd(1'b1, v); check("R5 mask write", v, 8'h5A);
        wr(1, 8'h00);
        pulse(8'h81);
        ack(v); check("R3 line0 highest after init", v, 8'h40);
        ack(v); check("R12 line7 last", v, 8'h47);
        check("R9 idle after auto end", int_out, 0);
    endtask

    task automatic t_base_only;
        logic [7:0] v;
        wr(0, 8'h12); wr(1, 8'hFC);
        check("R4 no mode word", cpu_mode86, 0);
        wr(1, 8'h33); rd(1'b1, v); check("R2 ready after base", v, 8'h33);
        wr(1, 8'h00);
        pulse(8'h20);
        ack(v); check("R8 vector wraps", v, 8'h01);
        wr(0, 8'h0B); rd(1'b0, v); check("R8 service set", v, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cascaded_nesting();
        t_level_hold();
        t_rotation();
        t_single_auto();
        t_base_only();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule